// File: doc/BRIEF.md
# Task Return Action Controller

This block remembers, for every processing element (PE) that is running a launched task, what has to happen to that task's result. It then carries that out when the PE reports that it is finished. When a task starts, the launcher presents the PE slot, the task ID, the parent and grandparent PE, a return action and a result format. The block stores these in one table entry per PE slot. For the grandparent action, the destination is resolved when the task is launched. If the grandparent is itself running in grandparent mode, the stored destination of the grandparent is inherited. Chains of such launches therefore send their result several levels up.

The block latches a completion pulse from a PE that has an entry, and handles completions one at a time. For every action except discard, it first reads the result out of the finished PE through a request/acknowledge handshake. The result then goes to one of two places:

- a result stream toward the destination PE, as one or two beats depending on the format;
- a merge buffer write port, where a per-parent counter tracks the arrivals and asks for a merge task once the expected number of arrivals is reached.

A task may also ask for a one-cycle host interrupt when it completes.

Top module: `ret_action_ctrl`

## Requirements
- R1: After reset, rd_req_o, res_valid_o, mbuf_we_o, merge_go_o and host_irq_o are all low.
- R2: The action code 0 (discard) frees the entry with no result readout, no result beat and no merge write. A later launch on the same PE slot is accepted.
- R3: For the action codes 1, 2 and 3, completion raises rd_req_o with rd_pe_o equal to the finished PE. Both stay unchanged until rd_ack_i, and rd_data_i is taken on that cycle.
- R4: For the action code 1 (parent) with the format code 0, exactly one beat is sent. Its data is the read value, res_dest_o is the parent PE, and res_last_o is high.
- R5: The format code 1 sends one beat whose top TID_W bits hold the task ID and whose lower bits hold the low bits of the value.
- R6: The format code 2 sends two beats: first the value with res_last_o low, then the zero-extended task ID with res_last_o high.
- R7: For the action code 3 (grandparent), res_dest_o is the grandparent PE. If that PE holds a live grandparent-mode entry at launch, the destination is that entry's stored destination instead.
- R8: For the action code 2 (merge), each result is written with mbuf_slot_o equal to the parent PE and mbuf_idx_o equal to the arrival count (starting at 0). On the arrival that reaches the launch's expected count, merge_go_o pulses with merge_count_o equal to that count, and the counter for that parent restarts at 0.
- R9: host_irq_o pulses for one cycle once per completed task launched with the interrupt flag set, and never for other tasks.
- R10: Completions on several PEs in the same cycle are all serviced, one after another, lowest PE index first.
- R11: A completion on a PE with no entry is ignored. A launch on a PE whose entry is live is ignored and leaves that entry unchanged.
- R12: While res_ready_i is low, res_valid_o, res_data_o, res_dest_o and res_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_valid_i | input | 1 | Launch record valid |
| launch_pe_i | input | PE_W | PE slot that runs the new task |
| launch_tid_i | input | TID_W | Task ID |
| launch_parent_i | input | PE_W | Parent PE |
| launch_gparent_i | input | PE_W | Grandparent PE |
| launch_action_i | input | 2 | 0 discard, 1 parent, 2 merge, 3 grandparent |
| launch_fmt_i | input | 2 | 0 value, 1 ID packed with value, 2 separate ID beat |
| launch_irq_i | input | 1 | Raise host interrupt on completion |
| launch_expect_i | input | CNT_W | Merge arrivals expected before a merge task is issued |
| pe_done_i | input | NUM_PE | Per-PE completion pulse |
| rd_req_o | output | 1 | Result readout request |
| rd_pe_o | output | PE_W | PE being read |
| rd_ack_i | input | 1 | Readout acknowledge, data valid |
| rd_data_i | input | DATA_W | Result value from the PE |
| res_valid_o | output | 1 | Result beat valid |
| res_ready_i | input | 1 | Result stream ready |
| res_dest_o | output | PE_W | Destination PE of the beat |
| res_data_o | output | DATA_W | Beat data |
| res_last_o | output | 1 | Last beat of the result |
| mbuf_we_o | output | 1 | Merge buffer write |
| mbuf_slot_o | output | PE_W | Merge buffer slot (parent PE) |
| mbuf_idx_o | output | CNT_W | Position within the slot |
| mbuf_data_o | output | DATA_W | Value written |
| merge_go_o | output | 1 | All expected merge results present |
| merge_count_o | output | CNT_W | Number of results to merge |
| host_irq_o | output | 1 | Host interrupt pulse |

## Verification
The bench builds the block with four PE slots, a 64-bit result, 8-bit task IDs and a 4-bit merge counter. Four slots are enough for:

- a two-level grandparent chain with a distinct final destination;
- a three-way merge whose completions arrive in the same cycle, which exercises the service order and the counter restart.

The 64-bit data and 8-bit ID widths let the test see at a glance which bits of a packed beat carry the ID and which carry the value.

// File: rtl/rac_pkg.sv
`timescale 1ns/1ps
package rac_pkg;
  typedef enum logic [1:0] {
    ACT_DISCARD = 2'd0,
    ACT_PARENT  = 2'd1,
    ACT_MERGE   = 2'd2,
    ACT_GRAND   = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    FMT_VAL   = 2'd0,
    FMT_PACK  = 2'd1,
    FMT_SPLIT = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SEND,
    ST_MERGE,
    ST_FIN
  } st_e;
endpackage

// File: rtl/rac_table.sv
`timescale 1ns/1ps
module rac_table
  import rac_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int PE_W   = 2,
  parameter int TID_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lv_i,
  input  logic [PE_W-1:0]   lpe_i,
  input  logic [TID_W-1:0]  ltid_i,
  input  logic [PE_W-1:0]   lpar_i,
  input  logic [PE_W-1:0]   lgp_i,
  input  logic [1:0]        lact_i,
  input  logic [1:0]        lfmt_i,
  input  logic              lirq_i,
  input  logic [CNT_W-1:0]  lexp_i,
  input  logic              clr_i,
  input  logic [PE_W-1:0]   clr_pe_i,
  input  logic [PE_W-1:0]   rd_pe_i,
  output logic [NUM_PE-1:0] valid_o,
  output logic [1:0]        r_act_o,
  output logic [1:0]        r_fmt_o,
  output logic              r_irq_o,
  output logic [TID_W-1:0]  r_tid_o,
  output logic [PE_W-1:0]   r_tgt_o,
  output logic [CNT_W-1:0]  r_exp_o
);
  logic [NUM_PE-1:0] v_q;
  logic [1:0]        act_q [NUM_PE];
  logic [1:0]        fmt_q [NUM_PE];
  logic              irq_q [NUM_PE];
  logic [TID_W-1:0]  tid_q [NUM_PE];
  logic [PE_W-1:0]   tgt_q [NUM_PE];
  logic [CNT_W-1:0]  exp_q [NUM_PE];
  logic [PE_W-1:0]   new_tgt;

  // destination resolved at launch; grandparent chains inherit the stored target
  always_comb begin
    new_tgt = lpar_i;
    if (lact_i == ACT_GRAND)
      new_tgt = (v_q[lgp_i] && act_q[lgp_i] == ACT_GRAND) ? tgt_q[lgp_i] : lgp_i;
    else if (lact_i == ACT_DISCARD)
      new_tgt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < NUM_PE; i++) begin
        act_q[i] <= '0;
        fmt_q[i] <= '0;
        irq_q[i] <= 1'b0;
        tid_q[i] <= '0;
        tgt_q[i] <= '0;
        exp_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PE; i++) begin
        if (clr_i && clr_pe_i == PE_W'(i)) begin
          v_q[i] <= 1'b0;
        end else if (lv_i && lpe_i == PE_W'(i) && !v_q[i]) begin
          v_q[i]   <= 1'b1;
          act_q[i] <= lact_i;
          fmt_q[i] <= lfmt_i;
          irq_q[i] <= lirq_i;
          tid_q[i] <= ltid_i;
          tgt_q[i] <= new_tgt;
          exp_q[i] <= lexp_i;
        end
      end
    end
  end

  assign valid_o = v_q;
  assign r_act_o = act_q[rd_pe_i];
  assign r_fmt_o = fmt_q[rd_pe_i];
  assign r_irq_o = irq_q[rd_pe_i];
  assign r_tid_o = tid_q[rd_pe_i];
  assign r_tgt_o = tgt_q[rd_pe_i];
  assign r_exp_o = exp_q[rd_pe_i];
endmodule

// File: rtl/rac_pend.sv
`timescale 1ns/1ps
module rac_pend #(
  parameter int NUM_PE = 4,
  parameter int PE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PE-1:0] done_i,
  input  logic [NUM_PE-1:0] valid_i,
  input  logic              take_i,
  input  logic [PE_W-1:0]   take_pe_i,
  output logic              any_o,
  output logic [PE_W-1:0]   sel_o
);
  logic [NUM_PE-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PE; i++) begin
        if (done_i[i] && valid_i[i]) pend_q[i] <= 1'b1;
        else if (take_i && take_pe_i == PE_W'(i)) pend_q[i] <= 1'b0;
      end
    end
  end

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (pend_q[i]) sel_o = PE_W'(i);
    end
  end

  assign any_o = |pend_q;
endmodule

// File: rtl/rac_merge.sv
`timescale 1ns/1ps
module rac_merge #(
  parameter int NUM_PE = 4,
  parameter int PE_W   = 2,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [PE_W-1:0]  slot_i,
  input  logic [CNT_W-1:0] exp_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q [NUM_PE];

  assign idx_o = cnt_q[slot_i];
  assign hit_o = ((CNT_W+1)'(idx_o) + (CNT_W+1)'(1)) >= {1'b0, exp_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PE; i++) cnt_q[i] <= '0;
    end else if (inc_i) begin
      for (int i = 0; i < NUM_PE; i++) begin
        if (slot_i == PE_W'(i)) cnt_q[i] <= hit_o ? '0 : cnt_q[i] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ret_action_ctrl.sv
`timescale 1ns/1ps
module ret_action_ctrl
  import rac_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 64,
  parameter int TID_W  = 8,
  parameter int CNT_W  = 4,
  localparam int PE_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_valid_i,
  input  logic [PE_W-1:0]   launch_pe_i,
  input  logic [TID_W-1:0]  launch_tid_i,
  input  logic [PE_W-1:0]   launch_parent_i,
  input  logic [PE_W-1:0]   launch_gparent_i,
  input  logic [1:0]        launch_action_i,
  input  logic [1:0]        launch_fmt_i,
  input  logic              launch_irq_i,
  input  logic [CNT_W-1:0]  launch_expect_i,
  input  logic [NUM_PE-1:0] pe_done_i,
  output logic              rd_req_o,
  output logic [PE_W-1:0]   rd_pe_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [PE_W-1:0]   res_dest_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_last_o,
  output logic              mbuf_we_o,
  output logic [PE_W-1:0]   mbuf_slot_o,
  output logic [CNT_W-1:0]  mbuf_idx_o,
  output logic [DATA_W-1:0] mbuf_data_o,
  output logic              merge_go_o,
  output logic [CNT_W-1:0]  merge_count_o,
  output logic              host_irq_o
);
  st_e               st_q;
  logic [PE_W-1:0]   cur_q;
  logic [DATA_W-1:0] val_q;
  logic              beat_q;

  logic [NUM_PE-1:0] tbl_valid, busy_mask;
  logic [PE_W-1:0]   look_pe, pend_sel;
  logic              pend_any, take, clr;
  logic [1:0]        r_act, r_fmt;
  logic              r_irq;
  logic [TID_W-1:0]  r_tid;
  logic [PE_W-1:0]   r_tgt;
  logic [CNT_W-1:0]  r_exp, m_idx;
  logic              m_hit;

  assign take    = (st_q == ST_IDLE) && pend_any;
  assign clr     = (st_q == ST_FIN);
  assign look_pe = (st_q == ST_IDLE) ? pend_sel : cur_q;

  // completions on an entry already in service are not re-queued
  always_comb begin
    busy_mask = '0;
    if (take) busy_mask[pend_sel] = 1'b1;
    else if (st_q != ST_IDLE) busy_mask[cur_q] = 1'b1;
  end

  rac_table #(
    .NUM_PE(NUM_PE), .PE_W(PE_W), .TID_W(TID_W), .CNT_W(CNT_W)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lv_i     (launch_valid_i),
    .lpe_i    (launch_pe_i),
    .ltid_i   (launch_tid_i),
    .lpar_i   (launch_parent_i),
    .lgp_i    (launch_gparent_i),
    .lact_i   (launch_action_i),
    .lfmt_i   (launch_fmt_i),
    .lirq_i   (launch_irq_i),
    .lexp_i   (launch_expect_i),
    .clr_i    (clr),
    .clr_pe_i (cur_q),
    .rd_pe_i  (look_pe),
    .valid_o  (tbl_valid),
    .r_act_o  (r_act),
    .r_fmt_o  (r_fmt),
    .r_irq_o  (r_irq),
    .r_tid_o  (r_tid),
    .r_tgt_o  (r_tgt),
    .r_exp_o  (r_exp)
  );

  rac_pend #(.NUM_PE(NUM_PE), .PE_W(PE_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (pe_done_i),
    .valid_i   (tbl_valid & ~busy_mask),
    .take_i    (take),
    .take_pe_i (pend_sel),
    .any_o     (pend_any),
    .sel_o     (pend_sel)
  );

  rac_merge #(.NUM_PE(NUM_PE), .PE_W(PE_W), .CNT_W(CNT_W)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (mbuf_we_o),
    .slot_i (r_tgt),
    .exp_i  (r_exp),
    .idx_o  (m_idx),
    .hit_o  (m_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      val_q  <= '0;
      beat_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take) begin
          cur_q <= pend_sel;
          st_q  <= (r_act == ACT_DISCARD) ? ST_FIN : ST_READ;
        end
        ST_READ: if (rd_ack_i) begin
          val_q  <= rd_data_i;
          beat_q <= 1'b0;
          st_q   <= (r_act == ACT_MERGE) ? ST_MERGE : ST_SEND;
        end
        ST_SEND: if (res_ready_i) begin
          if (res_last_o) st_q <= ST_FIN;
          else beat_q <= 1'b1;
        end
        ST_MERGE: st_q <= ST_FIN;
        ST_FIN:   st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o    = (st_q == ST_READ);
  assign rd_pe_o     = cur_q;

  assign res_valid_o = (st_q == ST_SEND);
  assign res_dest_o  = r_tgt;
  assign res_last_o  = res_valid_o && !((r_fmt == FMT_SPLIT) && !beat_q);

  always_comb begin
    res_data_o = val_q;
    if (r_fmt == FMT_PACK) res_data_o = {r_tid, val_q[DATA_W-TID_W-1:0]};
    else if (r_fmt == FMT_SPLIT && beat_q) res_data_o = DATA_W'(r_tid);
  end

  assign mbuf_we_o     = (st_q == ST_MERGE);
  assign mbuf_slot_o   = r_tgt;
  assign mbuf_idx_o    = m_idx;
  assign mbuf_data_o   = val_q;
  assign merge_go_o    = mbuf_we_o && m_hit;
  assign merge_count_o = r_exp;

  assign host_irq_o    = clr && r_irq;
endmodule

// File: rtl/rac_chk.sv
`timescale 1ns/1ps
module rac_chk #(
  parameter int PE_W   = 2,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [PE_W-1:0]   rd_pe_o,
  input logic              rd_ack_i,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [PE_W-1:0]   res_dest_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              res_last_o,
  input logic              mbuf_we_o,
  input logic              merge_go_o,
  input logic              host_irq_o
);
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_pe_o)); // R3

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o)
      && $stable(res_dest_o) && $stable(res_last_o)); // R12

  AST_SPLIT_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_ready_i && !res_last_o |=> res_valid_o && res_last_o); // R6

  AST_GO_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_go_o |-> mbuf_we_o); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |=> !host_irq_o); // R9

  AST_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, res_valid_o, mbuf_we_o, host_irq_o})); // R10
endmodule

bind ret_action_ctrl rac_chk #(.PE_W(PE_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_o    (rd_req_o),
  .rd_pe_o     (rd_pe_o),
  .rd_ack_i    (rd_ack_i),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_dest_o  (res_dest_o),
  .res_data_o  (res_data_o),
  .res_last_o  (res_last_o),
  .mbuf_we_o   (mbuf_we_o),
  .merge_go_o  (merge_go_o),
  .host_irq_o  (host_irq_o)
);

// File: tb/tb_ret_action_ctrl.sv
`timescale 1ns/1ps
module tb_ret_action_ctrl;
  localparam int NPE = 4, DW = 64, TW = 8, CW = 4, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          lv = 0;
  logic [PW-1:0] lpe = 0, lpar = 0, lgp = 0;
  logic [TW-1:0] ltid = 0;
  logic [1:0]    lact = 0, lfmt = 0;
  logic          lirq = 0;
  logic [CW-1:0] lexp = 0;
  logic [NPE-1:0] done = 0;
  logic          rd_req, rd_ack = 0;
  logic [PW-1:0] rd_pe;
  logic [DW-1:0] rd_data = 0;
  logic          res_valid, res_ready = 1, res_last;
  logic [PW-1:0] res_dest;
  logic [DW-1:0] res_data;
  logic          mb_we, m_go, irq;
  logic [PW-1:0] mb_slot;
  logic [CW-1:0] mb_idx, m_cnt;
  logic [DW-1:0] mb_data;

  ret_action_ctrl #(.NUM_PE(NPE), .DATA_W(DW), .TID_W(TW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .launch_valid_i(lv), .launch_pe_i(lpe), .launch_tid_i(ltid),
    .launch_parent_i(lpar), .launch_gparent_i(lgp), .launch_action_i(lact),
    .launch_fmt_i(lfmt), .launch_irq_i(lirq), .launch_expect_i(lexp),
    .pe_done_i(done),
    .rd_req_o(rd_req), .rd_pe_o(rd_pe), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_dest_o(res_dest),
    .res_data_o(res_data), .res_last_o(res_last),
    .mbuf_we_o(mb_we), .mbuf_slot_o(mb_slot), .mbuf_idx_o(mb_idx), .mbuf_data_o(mb_data),
    .merge_go_o(m_go), .merge_count_o(m_cnt), .host_irq_o(irq)
  );

  int checks = 0, errors = 0, salt = 0, cyc = 0;
  bit finished = 0;

  int rd_n, rs_n, mb_n, irq_n;
  logic [PW-1:0] rd_log [16];
  logic [DW-1:0] rs_d [16];
  logic [PW-1:0] rs_dst [16];
  logic          rs_last [16];
  logic [PW-1:0] mb_s [16];
  logic [CW-1:0] mb_i [16], mb_c [16];
  logic [DW-1:0] mb_d [16];
  logic          mb_g [16];

  function automatic logic [63:0] pval(input int pe);
    return 64'hF00D_0000_0000_0000 + 64'(pe) * 64'h0001_0001 + 64'(salt);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_logs();
    rd_n = 0; rs_n = 0; mb_n = 0; irq_n = 0; salt += 16;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic launch(input int pe, input int tid, input int par, input int gp,
                        input int act, input int fmt, input bit ir, input int ex);
    @(posedge clk); #1;
    lv = 1; lpe = PW'(pe); ltid = TW'(tid); lpar = PW'(par); lgp = PW'(gp);
    lact = 2'(act); lfmt = 2'(fmt); lirq = ir; lexp = CW'(ex);
    @(posedge clk); #1;
    lv = 0;
  endtask

  task automatic complete(input logic [NPE-1:0] m);
    @(posedge clk); #1;
    done = m;
    @(posedge clk); #1;
    done = '0;
  endtask

  // PE result readout model
  initial forever begin
    @(posedge clk); #1;
    rd_ack = rd_req;
    rd_data = rd_req ? pval(int'(rd_pe)) : '0;
  end

  // monitors
  always @(negedge clk) begin
    if (rd_req && rd_ack && rd_n < 16) begin rd_log[rd_n] = rd_pe; rd_n++; end
    if (res_valid && res_ready && rs_n < 16) begin
      rs_d[rs_n] = res_data; rs_dst[rs_n] = res_dest; rs_last[rs_n] = res_last; rs_n++;
    end
    if (mb_we && mb_n < 16) begin
      mb_s[mb_n] = mb_slot; mb_i[mb_n] = mb_idx; mb_d[mb_n] = mb_data;
      mb_g[mb_n] = m_go; mb_c[mb_n] = m_cnt; mb_n++;
    end
    if (irq) irq_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic t_reset();
    chk(!rd_req && !res_valid && !mb_we && !m_go && !irq, "R1 idle outputs",
        {59'd0, rd_req, res_valid, mb_we, m_go, irq}, 64'd0);
  endtask

  task automatic t_parent();
    clr_logs();
    launch(1, 'h21, 3, 0, 1, 0, 0, 0);
    complete(4'b0010);
    settle(20);
    chk(rd_n == 1 && rd_log[0] == 1, "R3 readout from PE1", 64'(rd_n), 64'd1);
    chk(rs_n == 1 && rs_last[0], "R4 single last beat", 64'(rs_n), 64'd1);
    chk(rs_d[0] == pval(1), "R4 value", rs_d[0], pval(1));
    chk(rs_dst[0] == 3, "R4 dest parent", 64'(rs_dst[0]), 64'd3);
    chk(irq_n == 0, "R9 no irq without flag", 64'(irq_n), 64'd0);
  endtask

  task automatic t_pack();
    logic [63:0] e;
    clr_logs();
    launch(2, 'h5A, 0, 0, 1, 1, 0, 0);
    complete(4'b0100);
    settle(20);
    e = {8'h5A, pval(2)[55:0]};
    chk(rs_n == 1, "R5 one beat", 64'(rs_n), 64'd1);
    chk(rs_d[0] == e && rs_dst[0] == 0, "R5 packed data", rs_d[0], e);
  endtask

  task automatic t_split();
    clr_logs();
    launch(3, 'h77, 1, 0, 1, 2, 1, 0);
    complete(4'b1000);
    settle(20);
    chk(rs_n == 2, "R6 two beats", 64'(rs_n), 64'd2);
    chk(rs_d[0] == pval(3) && !rs_last[0], "R6 first beat value", rs_d[0], pval(3));
    chk(rs_d[1] == 64'h77 && rs_last[1], "R6 second beat id", rs_d[1], 64'h77);
    chk(irq_n == 1, "R9 irq once", 64'(irq_n), 64'd1);
  endtask

  task automatic t_discard();
    clr_logs();
    launch(0, 'h10, 2, 0, 0, 0, 0, 0);
    complete(4'b0001);
    settle(20);
    chk(rd_n == 0 && rs_n == 0 && mb_n == 0, "R2 discard silent", 64'(rd_n + rs_n + mb_n), 64'd0);
    launch(0, 'h11, 2, 0, 1, 0, 0, 0);
    complete(4'b0001);
    settle(20);
    chk(rs_n == 1 && rs_dst[0] == 2, "R2 slot reusable", 64'(rs_n), 64'd1);
  endtask

  task automatic t_grand();
    clr_logs();
    launch(1, 'h31, 0, 3, 3, 0, 0, 0);
    launch(2, 'h32, 1, 1, 3, 0, 0, 0);
    complete(4'b0100);
    settle(20);
    chk(rs_n == 1 && rs_dst[0] == 3, "R7 cascaded dest", 64'(rs_dst[0]), 64'd3);
    complete(4'b0010);
    settle(20);
    chk(rs_n == 2 && rs_dst[1] == 3, "R7 grandparent dest", 64'(rs_dst[1]), 64'd3);
    launch(0, 'h33, 1, 2, 3, 0, 0, 0);
    complete(4'b0001);
    settle(20);
    chk(rs_n == 3 && rs_dst[2] == 2, "R7 plain grandparent", 64'(rs_dst[2]), 64'd2);
  endtask

  task automatic t_merge();
    clr_logs();
    launch(0, 'h40, 3, 0, 2, 0, 0, 3);
    launch(1, 'h41, 3, 0, 2, 0, 0, 3);
    launch(2, 'h42, 3, 0, 2, 0, 1, 3);
    complete(4'b0111);
    settle(40);
    chk(mb_n == 3 && rs_n == 0, "R8 three writes", 64'(mb_n), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk(rd_log[k] == PW'(k), "R10 lowest first", 64'(rd_log[k]), 64'(k));
      chk(mb_s[k] == 3 && mb_i[k] == CW'(k) && mb_d[k] == pval(k), "R8 slot/index/data",
          64'(mb_i[k]), 64'(k));
      chk(mb_g[k] == (k == 2), "R8 merge go timing", 64'(mb_g[k]), 64'(k == 2));
    end
    chk(mb_c[2] == 3, "R8 merge count", 64'(mb_c[2]), 64'd3);
    chk(irq_n == 1, "R9 irq only flagged", 64'(irq_n), 64'd1);
    launch(0, 'h43, 3, 0, 2, 0, 0, 1);
    complete(4'b0001);
    settle(20);
    chk(mb_n == 4 && mb_i[3] == 0 && mb_g[3], "R8 counter restart", 64'(mb_i[3]), 64'd0);
  endtask

  task automatic t_ignore();
    logic [63:0] e;
    clr_logs();
    complete(4'b1000);
    settle(20);
    chk(rd_n == 0 && rs_n == 0, "R11 done without entry", 64'(rd_n), 64'd0);
    launch(1, 'h11, 2, 0, 1, 1, 0, 0);
    launch(1, 'h99, 0, 0, 1, 0, 0, 0);
    complete(4'b0010);
    settle(20);
    e = {8'h11, pval(1)[55:0]};
    chk(rs_n == 1 && rs_dst[0] == 2, "R11 busy launch dropped dest", 64'(rs_dst[0]), 64'd2);
    chk(rs_d[0] == e, "R11 busy launch dropped data", rs_d[0], e);
  endtask

  task automatic t_backpressure();
    clr_logs();
    res_ready = 0;
    launch(2, 'h50, 1, 0, 1, 0, 0, 0);
    complete(4'b0100);
    settle(10);
    chk(res_valid && res_data == pval(2) && rs_n == 0, "R12 held while stalled", res_data, pval(2));
    settle(5);
    chk(res_valid && res_data == pval(2) && res_dest == 1, "R12 still held", res_data, pval(2));
    res_ready = 1;
    settle(10);
    chk(rs_n == 1 && !res_valid, "R12 released once", 64'(rs_n), 64'd1);
  endtask

  initial begin
    clr_logs();
    settle(3);
    t_reset();
    rst_n = 1;
    settle(2);
    t_reset();
    t_parent();
    t_pack();
    t_split();
    t_discard();
    t_grand();
    t_merge();
    t_ignore();
    t_backpressure();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule